// File: doc/BRIEF.md
# Serial Port Interrupt Flag Bank

This block keeps the pending interrupt causes of a serial port. Four causes come in from the serial engine: a pulse when a transmitted frame has fully left the shifter, a level that is high while the transmit buffer can accept data, a pulse when a received character is ready, and a pulse when the receiver had to drop a character. The three pulse causes are latched into sticky flags. The buffer-level cause is shown live and is never stored.

Software reaches the bank through a simple register port. One offset shows the flags, a second ORs written ones into them, a third clears the flags where ones are written, and a fourth holds an enable mask. Two interrupt lines leave the block. One carries the receive causes and the other the transmit causes, each gated by the mask, so the two can be served by separate handlers.

Top module: `irqf_regs`

## Requirements
- R1: After reset the stored flags and the enable mask are zero, and both interrupt lines are low.
- R2: Flag bit 0 is transmit complete, bit 1 is transmit buffer level, bit 2 is receive data ready and bit 4 is receive overflow. All other bits read as zero. The offsets are 0x40 for the flag view, 0x44 for the set alias, 0x48 for the clear alias and 0x4C for the enable mask.
- R3: A pulse on a pulse cause sets its flag on that clock edge, and the flag stays set until it is cleared.
- R4: A one written to the clear alias clears that flag on the write edge. Zero bits leave their flags unchanged.
- R5: Ones written to the set alias are ORed into flags 0, 2 and 4 on the write edge.
- R6: When a pulse cause and a clear write hit the same flag on one edge, the flag ends set.
- R7: Bit 1 always equals the transmit buffer level input. Writes to either alias do not change it.
- R8: The enable mask stores bits 0, 1, 2 and 4, reads them back, and reads zero in every other bit. Writing zero to it holds both interrupt lines low.
- R9: The receive line is the OR of (flag AND enable) over bits 2 and 4. The transmit line is the same OR over bits 0 and 1. Both lines follow the flag and mask state without delay.
- R10: Reads of the set alias, the clear alias and unmapped offsets return zero. The read data is zero when no read is requested.
- R11: Writes to the flag view offset are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte offset of the register |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, combinational |
| tx_done_i | input | 1 | Pulse: transmit frame complete |
| tx_room_i | input | 1 | Level: transmit buffer can accept data |
| rx_ready_i | input | 1 | Pulse: received character ready |
| rx_ovf_i | input | 1 | Pulse: receive overflow |
| irq_rx_o | output | 1 | Receive interrupt line |
| irq_tx_o | output | 1 | Transmit interrupt line |

## Verification
The bench aims at the following corner cases:
- A pulse cause that arrives on the same edge as a clear write for its flag. A design that gives the clear priority would lose the event.
- A write of zeros to the clear alias. A design that copies the written value instead of treating it as a mask would wipe every flag.
- Writes of bit 1 to the set alias, the clear alias and the flag view. A design that stores bit 1 or lets these writes through would show a level that the engine does not drive.
- An enable mask written with all ones, and then with zero. A design that keeps the unused bits would read them back. A design that does not gate the lines would keep an interrupt asserted.

// File: rtl/irqf_pkg.sv
package irqf_pkg;
  localparam int FLAG_W = 5;
  localparam int B_TXC  = 0;
  localparam int B_TXL  = 1;
  localparam int B_RXV  = 2;
  localparam int B_RXO  = 4;
  localparam logic [FLAG_W-1:0] STORE_MASK = FLAG_W'((1 << B_TXC) | (1 << B_RXV) | (1 << B_RXO));
  localparam logic [FLAG_W-1:0] LEVEL_MASK = FLAG_W'(1 << B_TXL);
  localparam logic [FLAG_W-1:0] VALID_MASK = STORE_MASK | LEVEL_MASK;
  localparam logic [FLAG_W-1:0] RX_MASK    = FLAG_W'((1 << B_RXV) | (1 << B_RXO));
  localparam logic [FLAG_W-1:0] TX_MASK    = FLAG_W'((1 << B_TXC) | (1 << B_TXL));

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_FLAG,
    SEL_SET,
    SEL_CLR,
    SEL_EN
  } reg_sel_e;
endpackage

// File: rtl/irqf_decode.sv
module irqf_decode
  import irqf_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] OFF_FLAG = ADDR_W'('h40),
  parameter logic [ADDR_W-1:0] OFF_SET  = ADDR_W'('h44),
  parameter logic [ADDR_W-1:0] OFF_CLR  = ADDR_W'('h48),
  parameter logic [ADDR_W-1:0] OFF_EN   = ADDR_W'('h4C)
) (
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  output reg_sel_e          sel_o,
  output logic              wr_o,
  output logic              rd_o
);
  always_comb begin
    unique case (addr_i)
      OFF_FLAG: sel_o = SEL_FLAG;
      OFF_SET:  sel_o = SEL_SET;
      OFF_CLR:  sel_o = SEL_CLR;
      OFF_EN:   sel_o = SEL_EN;
      default:  sel_o = SEL_NONE;
    endcase
  end

  assign wr_o = req_i & we_i;
  assign rd_o = req_i & ~we_i;
endmodule

// File: rtl/irqf_flags.sv
module irqf_flags
  import irqf_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [FLAG_W-1:0] set_i,
  input  logic [FLAG_W-1:0] clr_i,
  input  logic [FLAG_W-1:0] ev_i,
  input  logic [FLAG_W-1:0] lvl_i,
  output logic [FLAG_W-1:0] flags_o
);
  for (genvar i = 0; i < FLAG_W; i++) begin : g_bit
    if (STORE_MASK[i]) begin : g_sticky
      logic q;
      // event and set take priority over clear
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= 1'b0;
        else         q <= (q & ~clr_i[i]) | set_i[i] | ev_i[i];
      end
      assign flags_o[i] = q;
    end else if (LEVEL_MASK[i]) begin : g_level
      assign flags_o[i] = lvl_i[i];
    end else begin : g_zero
      assign flags_o[i] = 1'b0;
    end
  end

  logic [FLAG_W-1:0] kill_bits, raise_bits, quiet_bits;
  assign kill_bits  = clr_i & ~ev_i & ~set_i & STORE_MASK;
  assign raise_bits = (ev_i | set_i) & STORE_MASK;
  assign quiet_bits = ~(clr_i | ev_i | set_i) & STORE_MASK;

  AST_CLEAR_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kill_bits != '0 |=> (flags_o & $past(kill_bits)) == '0); // R4
  AST_EVENT_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    raise_bits != '0 |=> (flags_o & $past(raise_bits)) == $past(raise_bits)); // R6
  AST_FLAG_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    quiet_bits == STORE_MASK |=> $stable(flags_o & STORE_MASK)); // R11
endmodule

// File: rtl/irqf_route.sv
module irqf_route
  import irqf_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [FLAG_W-1:0] flags_i,
  input  logic [FLAG_W-1:0] en_i,
  output logic              irq_rx_o,
  output logic              irq_tx_o
);
  logic [FLAG_W-1:0] live;
  assign live     = flags_i & en_i;
  assign irq_rx_o = |(live & RX_MASK);
  assign irq_tx_o = |(live & TX_MASK);

  AST_MASK_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i == '0 |-> !irq_rx_o && !irq_tx_o); // R8
  AST_TX_NEEDS_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_tx_o |-> (flags_i[B_TXC] && en_i[B_TXC]) || (flags_i[B_TXL] && en_i[B_TXL])); // R9
endmodule

// File: rtl/irqf_regs.sv
module irqf_regs
  import irqf_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              tx_done_i,
  input  logic              tx_room_i,
  input  logic              rx_ready_i,
  input  logic              rx_ovf_i,
  output logic              irq_rx_o,
  output logic              irq_tx_o
);
  reg_sel_e          sel;
  logic              wr, rd;
  logic [FLAG_W-1:0] wbits, set_v, clr_v, ev_v, lvl_v, flags, en_q;

  irqf_decode #(.ADDR_W(ADDR_W)) u_decode (
    .req_i  (req_i),
    .we_i   (we_i),
    .addr_i (addr_i),
    .sel_o  (sel),
    .wr_o   (wr),
    .rd_o   (rd)
  );

  assign wbits = wdata_i[FLAG_W-1:0];
  assign set_v = (wr && sel == SEL_SET) ? (wbits & STORE_MASK) : '0;
  assign clr_v = (wr && sel == SEL_CLR) ? (wbits & STORE_MASK) : '0;

  always_comb begin
    ev_v        = '0;
    ev_v[B_TXC] = tx_done_i;
    ev_v[B_RXV] = rx_ready_i;
    ev_v[B_RXO] = rx_ovf_i;
    lvl_v        = '0;
    lvl_v[B_TXL] = tx_room_i;
  end

  irqf_flags u_flags (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (set_v),
    .clr_i   (clr_v),
    .ev_i    (ev_v),
    .lvl_i   (lvl_v),
    .flags_o (flags)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  en_q <= '0;
    else if (wr && sel == SEL_EN) en_q <= wbits & VALID_MASK;
  end

  irqf_route u_route (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .flags_i  (flags),
    .en_i     (en_q),
    .irq_rx_o (irq_rx_o),
    .irq_tx_o (irq_tx_o)
  );

  always_comb begin
    rdata_o = '0;
    if (rd) begin
      unique case (sel)
        SEL_FLAG: rdata_o = DATA_W'(flags);
        SEL_EN:   rdata_o = DATA_W'(en_q);
        default:  rdata_o = '0;
      endcase
    end
  end

  AST_ALIAS_READS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd && (sel == SEL_SET || sel == SEL_CLR) |-> rdata_o == '0); // R10
  AST_LEVEL_LIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd && sel == SEL_FLAG |-> rdata_o[B_TXL] == tx_room_i); // R7
endmodule

// File: tb/irqf_regs_test.sv
module irqf_regs_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        tx_done = 0, tx_room = 0, rx_ready = 0, rx_ovf = 0;
  logic        irq_rx, irq_tx;

  int checks = 0, errors = 0;
  logic [4:0] st_m = '0, en_m = '0;

  always #5 clk = ~clk;

  irqf_regs uut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .tx_done_i(tx_done), .tx_room_i(tx_room),
    .rx_ready_i(rx_ready), .rx_ovf_i(rx_ovf), .irq_rx_o(irq_rx), .irq_tx_o(irq_tx)
  );

  function automatic logic [4:0] view_flags();
    return st_m | (tx_room ? 5'b00010 : 5'b00000);
  endfunction

  function automatic logic [31:0] exp_rdata();
    if (!(req && !we)) return 32'd0;
    case (addr)
      8'h40:   return {27'd0, view_flags()};
      8'h4C:   return {27'd0, en_m};
      default: return 32'd0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic r, input logic w, input logic [7:0] a, input logic [31:0] d,
                     input logic txd, input logic txr, input logic rxv, input logic rxo,
                     input string tag);
    logic [4:0] setb, clrb, evb;
    @(negedge clk);
    req = r; we = w; addr = a; wdata = d;
    tx_done = txd; tx_room = txr; rx_ready = rxv; rx_ovf = rxo;
    #1;
    if (r && !w) chk(tag, rdata, exp_rdata());
    else         chk("R10 idle read data", rdata, 32'd0);
    chk("R9 irq_rx", {31'd0, irq_rx}, {31'd0, |(view_flags() & en_m & 5'b10100)});
    chk("R9 irq_tx", {31'd0, irq_tx}, {31'd0, |(view_flags() & en_m & 5'b00011)});
    setb = (r && w && a == 8'h44) ? (d[4:0] & 5'b10101) : 5'd0;
    clrb = (r && w && a == 8'h48) ? (d[4:0] & 5'b10101) : 5'd0;
    evb  = {rxo, 1'b0, rxv, 1'b0, txd};
    st_m = (st_m & ~clrb) | setb | evb;
    if (r && w && a == 8'h4C) en_m = d[4:0] & 5'b10111;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] offs [5];
    offs[0] = 8'h40; offs[1] = 8'h44; offs[2] = 8'h48; offs[3] = 8'h4C; offs[4] = 8'h50;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_ni = 1'b1;

    // reset state
    cyc(1, 0, 8'h40, 0, 0, 0, 0, 0, "R1 flags after reset");
    cyc(1, 0, 8'h4C, 0, 0, 0, 0, 0, "R1 enable after reset");
    // enable mask write/read
    cyc(1, 1, 8'h4C, 32'hFFFF_FFFF, 0, 0, 0, 0, "R8");
    cyc(1, 0, 8'h4C, 0, 0, 0, 0, 0, "R8 enable unused bits zero");
    chk("R8 enable literal", rdata, 32'h17);
    // event sets, sticky
    cyc(0, 0, 8'h00, 0, 1, 0, 0, 0, "R3");
    cyc(0, 0, 8'h00, 0, 0, 0, 0, 0, "R3");
    cyc(1, 0, 8'h40, 0, 0, 0, 0, 0, "R3 transmit complete sticky");
    chk("R3 flag literal", rdata, 32'h1);
    // clear alias
    cyc(1, 1, 8'h48, 32'h0, 0, 0, 0, 0, "R4");
    cyc(1, 0, 8'h40, 0, 0, 0, 0, 0, "R4 zero clear no effect");
    cyc(1, 1, 8'h48, 32'h1, 0, 0, 0, 0, "R4");
    cyc(1, 0, 8'h40, 0, 0, 0, 0, 0, "R4 clear one");
    chk("R4 flag literal", rdata, 32'h0);
    // event vs clear
    cyc(1, 1, 8'h48, 32'h14, 0, 0, 1, 0, "R6");
    cyc(1, 0, 8'h40, 0, 0, 0, 0, 0, "R6 event beats clear");
    chk("R6 flag literal", rdata, 32'h4);
    // set alias
    cyc(1, 1, 8'h44, 32'h10, 0, 0, 0, 0, "R5");
    cyc(1, 0, 8'h40, 0, 0, 0, 0, 0, "R5 set alias ORs");
    cyc(1, 1, 8'h44, 32'h2, 0, 0, 0, 0, "R7");
    cyc(1, 0, 8'h40, 0, 0, 0, 0, 0, "R7 set cannot force level bit");
    cyc(1, 0, 8'h40, 0, 0, 1, 0, 0, "R7 level bit follows input");
    cyc(1, 1, 8'h48, 32'h2, 0, 1, 0, 0, "R7");
    cyc(1, 0, 8'h40, 0, 0, 1, 0, 0, "R7 clear cannot drop level bit");
    chk("R2 bit positions", rdata, 32'h16);
    // flag view read-only
    cyc(1, 1, 8'h40, 32'hFFFF_FFFF, 0, 1, 0, 0, "R11");
    cyc(1, 0, 8'h40, 0, 0, 1, 0, 0, "R11 flag view write ignored");
    // alias reads
    cyc(1, 0, 8'h44, 0, 0, 1, 0, 0, "R10 set alias reads zero");
    cyc(1, 0, 8'h48, 0, 0, 1, 0, 0, "R10 clear alias reads zero");
    cyc(1, 0, 8'h50, 0, 0, 1, 0, 0, "R10 unmapped reads zero");
    // mask all
    cyc(1, 1, 8'h4C, 32'h0, 0, 1, 0, 0, "R8");
    cyc(0, 0, 8'h00, 0, 0, 1, 1, 1, "R8 masked lines");
    chk("R8 lines low with zero mask", {30'd0, irq_rx, irq_tx}, 32'd0);

    // random phase
    void'($urandom(32'h5EED_1234));
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] rv;
      logic [7:0]  a;
      rv = $urandom();
      a  = offs[rv[2:0] % 5];
      cyc(rv[3], rv[4], a, $urandom(), (rv[7:5] == 0), rv[8], (rv[11:9] == 0), (rv[14:12] == 0),
          (a == 8'h4C) ? "R8 random enable read" : (a == 8'h40) ? "R3 random flag read" : "R10 random read");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule